// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is a read-only, direct-mapped cache with a small fully associative victim buffer beside it. The buffer holds only lines pushed out of the main array by refills. A request that misses the main array searches every victim entry before anything is sent to lower memory. When the block is found there, it trades places with the line currently at the missing index, and no memory access is made. When it is not found, a single block read goes to memory. The returned block is installed in the main array, and the line it replaces drops into the victim buffer in the same cycle.

Each storage unit is a single block of `DATA_W` bits, addressed by its block address. The low `INDEX_W` bits select the main line and the remaining bits form its tag. Requests arrive on a valid/ready channel and there is one transaction in flight at a time. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The response is offered on `rsp_valid` and stays frozen until `rsp_ready` is seen. The memory request channel is also valid/ready. The memory response is a plain strobe, which the block accepts in any cycle while it waits for a refill. A pair of counters records how many main-array misses the victim buffer absorbed and how many went to memory.

Top module: `vcache_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, both counters read 0, and every main line and victim entry is empty, so the first access to any block is served by memory.
- R2: A request whose tag matches a valid main line at its index returns that line's data with `rsp_src` = 0. It makes no memory request and changes neither counter.
- R3: On a main miss that matches a victim entry, the response carries the victim data with `rsp_src` = 1, no memory request is made, and `vhit_count` rises by one. The found block moves into the main line. The line it displaces goes into the victim buffer as its newest entry, so a later request for it is a victim hit.
- R4: On a miss in both structures, exactly one memory request is issued carrying the full block address. `vmiss_count` rises by one, and the memory data is returned with `rsp_src` = 2 and installed in the main line.
- R5: When a refill replaces a valid main line, that line enters the victim buffer in the same cycle. A refill into an empty line inserts nothing.
- R6: The victim buffer keeps entries in insertion order. Inserting into a full buffer of `VDEPTH` entries discards the oldest one. An entry removed by a swap frees its slot and leaves the order of the rest unchanged.
- R7: `req_ready` is high only while no transaction is in flight. After a request is accepted it stays low until the response handshake completes.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_src` hold their values.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request and `mem_req_addr` hold. The refill completes only when `mem_rsp_valid` is seen.
- R10: Each counter changes only by an increment of one, and the two never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Block address of the request |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Block data |
| rsp_src | output | 2 | 0 main hit, 1 victim hit, 2 memory |
| mem_req_valid | output | 1 | Memory read request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Block address to read |
| mem_rsp_valid | input | 1 | Memory data strobe |
| mem_rsp_data | input | DATA_W | Memory data |
| vhit_count | output | CNT_W | Misses absorbed by the victim buffer |
| vmiss_count | output | CNT_W | Misses sent to memory |

## Verification
The bench builds the block with `INDEX_W` = 2 over an 8-bit block address and keeps the default four victim entries. With only four main lines, a short run of addresses that share an index produces conflict misses, swaps and FIFO overflow of the victim buffer. A scripted opening sequence reaches each path in turn. A pseudo-random stream then draws from eight tags on two indices, while response back-pressure and a stalling memory request channel exercise the hold rules. A behavioural model built on a queue predicts the source, data and counters of every response, and it predicts whether each memory request should appear at all.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN   = 2'd0,
    SRC_VICTIM = 2'd1,
    SRC_MEM    = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } state_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_data
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0]  line_vld;
  logic [TAG_W-1:0]  line_tag [LINES];
  logic [DATA_W-1:0] line_dat [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) line_vld <= '0;
    else if (wr_en) line_vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_tag[wr_idx] <= wr_tag;
      line_dat[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = line_vld[rd_idx];
  assign rd_tag   = line_tag[rd_idx];
  assign rd_data  = line_dat[rd_idx];
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  input  logic              swap_en,
  input  logic              insert_en,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [CNT_W-1:0]  fill_count
);
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [ADDR_W-1:0] sh_addr  [DEPTH];
  logic [DATA_W-1:0] sh_data  [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [DEPTH-1:0]  match;
  logic [IDX_W-1:0]  hit_idx;
  logic              rm_en;
  logic [IDX_W-1:0]  rm_idx;
  logic [CNT_W-1:0]  cnt_mid;
  logic              wr_en;

  // parallel tag search over the occupied entries
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = (CNT_W'(i) < cnt) && (ent_addr[i] == lk_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit      = |match;
  assign hit_data = ent_data[hit_idx];

  // removal: the swapped entry, or the oldest one when full on insert
  always_comb begin
    rm_en  = 1'b0;
    rm_idx = '0;
    if (swap_en && hit) begin
      rm_en  = 1'b1;
      rm_idx = hit_idx;
    end else if (insert_en && in_valid && cnt == CNT_W'(DEPTH)) begin
      rm_en  = 1'b1;
    end
  end

  assign cnt_mid = cnt - CNT_W'(rm_en);
  assign wr_en   = ((swap_en && hit) || insert_en) && in_valid;

  // close the gap left by a removal: entries above it move down by one
  for (genvar i = 0; i < DEPTH; i++) begin : g_shift
    if (i < DEPTH - 1) begin : g_mid
      assign sh_addr[i] = (rm_en && IDX_W'(i) >= rm_idx) ? ent_addr[i+1] : ent_addr[i];
      assign sh_data[i] = (rm_en && IDX_W'(i) >= rm_idx) ? ent_data[i+1] : ent_data[i];
    end else begin : g_top
      assign sh_addr[i] = ent_addr[i];
      assign sh_data[i] = ent_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_mid + CNT_W'(wr_en);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && cnt_mid == CNT_W'(i)) begin
        ent_addr[i] <= in_addr;
        ent_data[i] <= in_data;
      end else begin
        ent_addr[i] <= sh_addr[i];
        ent_data[i] <= sh_data[i];
      end
    end
  end

  assign fill_count = cnt;
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int INDEX_W = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  localparam int TAG_W  = ADDR_W - INDEX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_src,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  vhit_count,
  output logic [CNT_W-1:0]  vmiss_count,
  output logic [ADDR_W-1:0] look_addr,
  input  logic              line_valid,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              line_wr,
  output logic [TAG_W-1:0]  line_wr_tag,
  output logic [DATA_W-1:0] line_wr_data,
  input  logic              v_hit,
  input  logic [DATA_W-1:0] v_data,
  output logic              v_swap,
  output logic              v_insert,
  output logic              v_in_valid,
  output logic [ADDR_W-1:0] v_in_addr,
  output logic [DATA_W-1:0] v_in_data
);
  state_e            st;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  src_e              src_q;
  logic [TAG_W-1:0]  tag_q;
  logic [INDEX_W-1:0] idx_q;
  logic              main_hit;
  logic              lookup;

  assign tag_q    = addr_q[ADDR_W-1:INDEX_W];
  assign idx_q    = addr_q[INDEX_W-1:0];
  assign lookup   = (st == ST_LOOKUP);
  assign main_hit = line_valid && (line_tag == tag_q);

  assign v_swap       = lookup && !main_hit && v_hit;
  assign v_insert     = (st == ST_MWAIT) && mem_rsp_valid;
  assign v_in_valid   = line_valid;
  assign v_in_addr    = {line_tag, idx_q};
  assign v_in_data    = line_data;
  assign line_wr      = v_swap || v_insert;
  assign line_wr_tag  = tag_q;
  assign line_wr_data = v_swap ? v_data : mem_rsp_data;

  assign look_addr     = addr_q;
  assign req_ready     = (st == ST_IDLE);
  assign rsp_valid     = (st == ST_RESP);
  assign rsp_data      = data_q;
  assign rsp_src       = src_q;
  assign mem_req_valid = (st == ST_MREQ);
  assign mem_req_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      addr_q      <= '0;
      data_q      <= '0;
      src_q       <= SRC_MAIN;
      vhit_count  <= '0;
      vmiss_count <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          st     <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (main_hit) begin
            data_q <= line_data;
            src_q  <= SRC_MAIN;
            st     <= ST_RESP;
          end else if (v_hit) begin
            data_q     <= v_data;
            src_q      <= SRC_VICTIM;
            vhit_count <= vhit_count + CNT_W'(1);
            st         <= ST_RESP;
          end else begin
            vmiss_count <= vmiss_count + CNT_W'(1);
            st          <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) st <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          data_q <= mem_rsp_data;
          src_q  <= SRC_MEM;
          st     <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcache_top.sv
module vcache_top #(
  parameter int ADDR_W  = 12,
  parameter int INDEX_W = 4,
  parameter int DATA_W  = 32,
  parameter int VDEPTH  = 4,
  parameter int CNT_W   = 16,
  localparam int TAG_W  = ADDR_W - INDEX_W,
  localparam int VCNT_W = $clog2(VDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_src,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  vhit_count,
  output logic [CNT_W-1:0]  vmiss_count
);
  logic [ADDR_W-1:0] look_addr;
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              line_wr;
  logic [TAG_W-1:0]  line_wr_tag;
  logic [DATA_W-1:0] line_wr_data;
  logic              v_hit;
  logic [DATA_W-1:0] v_data;
  logic              v_swap;
  logic              v_insert;
  logic              v_in_valid;
  logic [ADDR_W-1:0] v_in_addr;
  logic [DATA_W-1:0] v_in_data;
  logic [VCNT_W-1:0] v_count;

  vc_main_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_main (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_addr[INDEX_W-1:0]), .rd_valid(line_valid),
    .rd_tag(line_tag), .rd_data(line_data),
    .wr_en(line_wr), .wr_idx(look_addr[INDEX_W-1:0]),
    .wr_tag(line_wr_tag), .wr_data(line_wr_data)
  );

  vc_victim_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(VDEPTH)) u_vict (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(look_addr), .hit(v_hit), .hit_data(v_data),
    .swap_en(v_swap), .insert_en(v_insert), .in_valid(v_in_valid),
    .in_addr(v_in_addr), .in_data(v_in_data), .fill_count(v_count)
  );

  vc_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_src(rsp_src),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .vhit_count(vhit_count), .vmiss_count(vmiss_count),
    .look_addr(look_addr),
    .line_valid(line_valid), .line_tag(line_tag), .line_data(line_data),
    .line_wr(line_wr), .line_wr_tag(line_wr_tag), .line_wr_data(line_wr_data),
    .v_hit(v_hit), .v_data(v_data), .v_swap(v_swap), .v_insert(v_insert),
    .v_in_valid(v_in_valid), .v_in_addr(v_in_addr), .v_in_data(v_in_data)
  );
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int VDEPTH = 4,
  parameter int VCNT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [1:0]        rsp_src,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [CNT_W-1:0]  vhit_count,
  input logic [CNT_W-1:0]  vmiss_count,
  input logic [VCNT_W-1:0] v_count
);
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_src));

  assert_mreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_vhit_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vhit_count != $past(vhit_count) |-> vhit_count == $past(vhit_count) + CNT_W'(1));

  assert_vmiss_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vmiss_count != $past(vmiss_count) |-> vmiss_count == $past(vmiss_count) + CNT_W'(1)
      && vhit_count == $past(vhit_count));

  assert_victim_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vhit_count != $past(vhit_count) |-> rsp_valid && rsp_src == 2'd1 && !mem_req_valid);

  assert_miss_to_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vmiss_count != $past(vmiss_count) |-> mem_req_valid && !rsp_valid);

  assert_fifo_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v_count <= VCNT_W'(VDEPTH));

  assert_src_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_src != 2'd3);
endmodule

bind vcache_top vc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .VDEPTH(VDEPTH), .VCNT_W(VCNT_W)
) u_vc_checker (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_src(rsp_src),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .vhit_count(vhit_count), .vmiss_count(vmiss_count), .v_count(v_count)
);

// File: tb/tb_vcache_top.sv
module tb_vcache_top;
  localparam int ADDR_W  = 8;
  localparam int INDEX_W = 2;
  localparam int DATA_W  = 32;
  localparam int VDEPTH  = 4;
  localparam int CNT_W   = 16;
  localparam int LINES   = 1 << INDEX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [DATA_W-1:0] rsp_data;
  logic [1:0]        rsp_src;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic [CNT_W-1:0]  vhit_count;
  logic [CNT_W-1:0]  vmiss_count;

  always #10 clk = ~clk;

  vcache_top #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W),
               .VDEPTH(VDEPTH), .CNT_W(CNT_W)) dut (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // reference model
  int mtag [LINES];
  bit mvld [LINES];
  int vq [$];
  int exp_vhit = 0;
  int exp_vmiss = 0;
  int cur_addr = 0;
  bit mem_expected = 1'b0;

  function automatic logic [31:0] memf(input int a);
    logic [31:0] x;
    x = 32'(a) * 32'h0101_0101;
    return x ^ 32'hA55A_1357;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic predict(input int a, output int src);
    int idx, tg, pos;
    idx = a % LINES;
    tg  = a / LINES;
    pos = -1;
    if (mvld[idx] && mtag[idx] == tg) begin
      src = 0;
      return;
    end
    for (int k = 0; k < vq.size(); k++) if (vq[k] == a) pos = k;
    if (pos >= 0) begin
      vq.delete(pos);
      if (mvld[idx]) vq.push_back(mtag[idx] * LINES + idx);
      exp_vhit++;
      src = 1;
    end else begin
      if (mvld[idx]) begin
        if (vq.size() == VDEPTH) void'(vq.pop_front());
        vq.push_back(mtag[idx] * LINES + idx);
      end
      exp_vmiss++;
      src = 2;
    end
    mtag[idx] = tg;
    mvld[idx] = 1'b1;
  endtask

  task automatic do_req(input int a, input int hold, input int want_src, input string tag);
    int src, w;
    logic [DATA_W-1:0] first;
    predict(a, src);
    if (want_src >= 0) chk({tag, " scripted source"}, 64'(src), 64'(want_src));
    cur_addr = a;
    mem_expected = (src == 2);
    @(negedge clk);
    chk("R7 ready while idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 ready low in flight", 64'(req_ready), 64'd0);
    w = 0;
    while (!rsp_valid && w < 200) begin
      @(negedge clk);
      w++;
    end
    chk("R7 response arrives", 64'(rsp_valid), 64'd1);
    first = rsp_data;
    for (int d = 0; d < hold; d++) begin
      @(negedge clk);
      chk("R8 held valid", 64'(rsp_valid), 64'd1);
      chk("R8 held data", 64'(rsp_data), 64'(first));
    end
    chk({tag, " data"}, 64'(rsp_data), 64'(memf(a)));
    chk({tag, " source"}, 64'(rsp_src), 64'(src));
    chk("R10 vhit_count", 64'(vhit_count), 64'(exp_vhit));
    chk("R10 vmiss_count", 64'(vmiss_count), 64'(exp_vmiss));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 released", 64'(rsp_valid), 64'd0);
  endtask

  // memory responder with a stalling request channel (R9)
  initial begin
    int cyc, pend;
    int pend_addr;
    cyc = 0;
    pend = 0;
    pend_addr = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memf(pend_addr);
        end
      end
      mem_req_ready = (cyc % 3) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        chk("R4 memory request expected (R3 no request on victim hit)", 64'(mem_expected), 64'd1);
        chk("R9 memory address", 64'(mem_req_addr), 64'(cur_addr));
        mem_expected = 1'b0;
        pend = 3;
        pend_addr = int'(mem_req_addr);
      end
    end
  end

  initial begin
    int lfsr, a;
    for (int i = 0; i < LINES; i++) begin
      mvld[i] = 1'b0;
      mtag[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R1 vhit_count", 64'(vhit_count), 64'd0);
    chk("R1 vmiss_count", 64'(vmiss_count), 64'd0);

    do_req(8'h01, 0, 2, "R1 cold miss");
    do_req(8'h01, 2, 0, "R2 main hit");
    do_req(8'h05, 0, 2, "R4 conflict refill");
    do_req(8'h01, 1, 1, "R3 victim hit swap");
    do_req(8'h01, 0, 0, "R3 swapped block in main");
    do_req(8'h05, 0, 1, "R3 displaced line in victim");
    do_req(8'h02, 0, 2, "R5 empty line refill");
    do_req(8'h06, 0, 2, "R5 refill over valid line");
    do_req(8'h02, 0, 1, "R5 displaced line found");
    // victim holds 01,06 ; fill past four entries
    do_req(8'h09, 0, 2, "R6 fill");
    do_req(8'h0D, 0, 2, "R6 fill");
    do_req(8'h11, 0, 2, "R6 full");
    do_req(8'h15, 0, 2, "R6 overflow");
    do_req(8'h01, 0, 2, "R6 oldest discarded");
    do_req(8'h11, 0, 1, "R6 newer kept");

    lfsr = 32'h1ACE;
    for (int n = 0; n < 150; n++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      a = ((lfsr >> 3) & 7) * LINES + (lfsr & 1);
      do_req(a, (lfsr >> 7) & 3, -1, "R3 R4 random stream");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule